// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block decides which of up to N interrupt-controller targets should receive an inter-processor or message-signalled interrupt. A request carries a command word, an 8-bit destination and the index of the sending target. Each target supplies three things: its physical ID, a logical-ID register and a format register that holds its logical model. From these the block forms an N-bit delivery mask. The transport that then carries the interrupt reads this mask.

The destination can be read in two ways. In physical mode it is either a broadcast or one exact ID. In logical mode it is matched per target, in flat form or in cluster form. A two-bit shorthand in the command word can bypass the destination entirely: it can select only the sender, every target, or every target except the sender. For lowest-priority delivery the mask is reduced to the single lowest-indexed selected target. Targets flagged as absent never appear in the mask. The result is registered one cycle after the request strobe and comes with its own valid flag.

Top module: `irq_target_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, maskValid is 0 and deliverMask is all zeros.
- R2: maskValid is 1 in exactly the cycle after a cycle with reqValid high. deliverMask in that cycle reflects the inputs sampled with that strobe.
- R3: When shorthand reqCmd[19:18] is 0 and mode bit reqCmd[11] is 0 (physical), a destId of 0xFF selects every present target.
- R4: In physical mode, any destId other than 0xFF selects each present target whose physical ID equals destId. If no target has that ID, the mask is zero.
- R5: In logical mode (reqCmd[11] = 1), a target whose model field fmtReg[31:28] is 0xF is selected when destId AND its logical ID (logReg[31:24]) is nonzero.
- R6: In logical mode, a target whose model field is 0x0 is selected when two conditions both hold: the upper nibbles of destId and its logical ID are equal, and the two lower nibbles share at least one set bit.
- R7: In logical mode, a target whose model field is neither 0xF nor 0x0 is never selected. Bits 23:0 of the logical-ID register and bits 27:0 of the format register have no effect.
- R8: Shorthand 1 selects only the target at senderIdx. Shorthand 2 selects all present targets. Shorthand 3 selects all present targets except senderIdx. In all three cases destId and the mode bit are ignored.
- R9: When the delivery mode reqCmd[10:8] equals 1 (lowest priority), only the lowest-indexed bit of the otherwise selected mask is kept. Every other delivery mode keeps the full mask.
- R10: A target whose tgtPresent bit is 0 is never selected, including by broadcast and by the shorthand codes.
- R11: In a cycle with no strobe, deliverMask holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqCmd | input | 32 | Command word: shorthand [19:18], destination mode [11], delivery mode [10:8] |
| destId | input | 8 | Destination field |
| senderIdx | input | IDX_W | Index of the sending target |
| tgtPresent | input | N | Per-target presence flags |
| tgtPhysId | input | 8*N | Physical ID of each target, target i at [8i+7:8i] |
| tgtLogReg | input | 32*N | Logical-ID register of each target, logical ID in bits 31:24 |
| tgtFmtReg | input | 32*N | Format register of each target, model in bits 31:28 |
| maskValid | output | 1 | Mask valid, one cycle after the strobe |
| deliverMask | output | N | Registered delivery mask |

## Verification
The hardest case to reach is where the target configuration, rather than the destination, decides the outcome. Examples are cluster matching across two clusters, a model code that must match nothing even though its logical ID would hit everything, and an absent target inside a broadcast. The bench loads three contrasting target configurations: flat, clustered with one target absent, and mixed with invalid models. For each configuration it sweeps every destination value across all shorthands, both destination modes and both kinds of delivery mode. It issues one strobe per cycle, so back-to-back updates are covered as well.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int unsigned CMD_W    = 32;
  localparam int unsigned ID_W     = 8;
  localparam int unsigned REG_W    = 32;

  // command word field positions
  localparam int unsigned SH_LO    = 18;
  localparam int unsigned SH_HI    = 19;
  localparam int unsigned DM_BIT   = 11;
  localparam int unsigned DLV_LO   = 8;
  localparam int unsigned DLV_HI   = 10;

  // per-target register field positions
  localparam int unsigned LOGID_LO = 24;
  localparam int unsigned LOGID_HI = 31;
  localparam int unsigned MODEL_LO = 28;
  localparam int unsigned MODEL_HI = 31;

  localparam logic [ID_W-1:0] BCAST_ID      = 8'hFF;
  localparam logic [3:0]      MODEL_FLAT    = 4'hF;
  localparam logic [3:0]      MODEL_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    SH_NONE     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL_INCL = 2'd2,
    SH_ALL_EXCL = 2'd3
  } shorthand_e;

  typedef enum logic [2:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWEST = 3'd1
  } delivery_e;

  typedef struct packed {
    logic load;
    logic useDest;
    logic logical;
    logic selfOnly;
    logic dropSelf;
    logic keepLowest;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CMD_W-1:0] reqCmd,
  output ctrlStrobe_t      strb,
  output logic             maskValid
);

  shorthand_e shortSel;
  delivery_e  dlvMode;
  logic       unusedCmdBits;

  assign shortSel      = shorthand_e'(reqCmd[SH_HI:SH_LO]);
  assign dlvMode       = delivery_e'(reqCmd[DLV_HI:DLV_LO]);
  assign unusedCmdBits = ^{reqCmd[CMD_W-1:SH_HI+1], reqCmd[SH_LO-1:DM_BIT+1],
                           reqCmd[DLV_LO-1:0]};

  always_comb begin
    strb            = '0;
    strb.load       = reqValid;
    strb.useDest    = (shortSel == SH_NONE);
    strb.logical    = reqCmd[DM_BIT];
    strb.selfOnly   = (shortSel == SH_SELF);
    strb.dropSelf   = (shortSel == SH_ALL_EXCL);
    strb.keepLowest = (dlvMode == DLV_LOWEST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskValid <= 1'b0;
    else       maskValid <= reqValid;
  end

endmodule

// File: rtl/irq_sel_match.sv
module irq_sel_match
  import irq_sel_pkg::*;
(
  input  logic [ID_W-1:0]  destId,
  input  logic [ID_W-1:0]  physId,
  input  logic [REG_W-1:0] logReg,
  input  logic [REG_W-1:0] fmtReg,
  output logic             physHit,
  output logic             logHit
);

  logic [ID_W-1:0] logId;
  logic [3:0]      model;
  logic            unusedRegBits;

  assign logId         = logReg[LOGID_HI:LOGID_LO];
  assign model         = fmtReg[MODEL_HI:MODEL_LO];
  assign unusedRegBits = ^{logReg[LOGID_LO-1:0], fmtReg[MODEL_LO-1:0]};

  assign physHit = (destId == BCAST_ID) || (physId == destId);

  always_comb begin
    unique case (model)
      MODEL_FLAT:    logHit = |(destId & logId);
      MODEL_CLUSTER: logHit = (destId[7:4] == logId[7:4]) &&
                              (|(destId[3:0] & logId[3:0]));
      default:       logHit = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [ID_W-1:0]    destId,
  input  logic [IDX_W-1:0]   senderIdx,
  input  logic [N-1:0]       tgtPresent,
  input  logic [N*ID_W-1:0]  tgtPhysId,
  input  logic [N*REG_W-1:0] tgtLogReg,
  input  logic [N*REG_W-1:0] tgtFmtReg,
  output logic [N-1:0]       deliverMask
);

  logic [N-1:0] physVec;
  logic [N-1:0] logVec;
  logic [N-1:0] selfVec;
  logic [N-1:0] destVec;
  logic [N-1:0] shortVec;
  logic [N-1:0] presentVec;
  logic [N-1:0] lowestVec;
  logic [N-1:0] nextMask;

  for (genvar gi = 0; gi < N; gi++) begin : g_tgt
    irq_sel_match u_match (
      .destId  (destId),
      .physId  (tgtPhysId[gi*ID_W +: ID_W]),
      .logReg  (tgtLogReg[gi*REG_W +: REG_W]),
      .fmtReg  (tgtFmtReg[gi*REG_W +: REG_W]),
      .physHit (physVec[gi]),
      .logHit  (logVec[gi])
    );
    assign selfVec[gi] = (senderIdx == IDX_W'(gi));
  end

  assign destVec = strb.logical ? logVec : physVec;

  always_comb begin
    if (strb.useDest)       shortVec = destVec;
    else if (strb.selfOnly) shortVec = selfVec;
    else if (strb.dropSelf) shortVec = ~selfVec;
    else                    shortVec = '1;
  end

  assign presentVec = shortVec & tgtPresent;
  assign lowestVec  = presentVec & (~presentVec + N'(1));
  assign nextMask   = strb.keepLowest ? lowestVec : presentVec;

  always_ff @(posedge clk) begin
    if (!rstN)          deliverMask <= '0;
    else if (strb.load) deliverMask <= nextMask;
  end

endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CMD_W-1:0]   reqCmd,
  input  logic [ID_W-1:0]    destId,
  input  logic [IDX_W-1:0]   senderIdx,
  input  logic [N-1:0]       tgtPresent,
  input  logic [N*ID_W-1:0]  tgtPhysId,
  input  logic [N*REG_W-1:0] tgtLogReg,
  input  logic [N*REG_W-1:0] tgtFmtReg,
  output logic               maskValid,
  output logic [N-1:0]       deliverMask
);

  ctrlStrobe_t strb;

  irq_sel_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCmd    (reqCmd),
    .strb      (strb),
    .maskValid (maskValid)
  );

  irq_sel_dp #(.N(N), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .destId      (destId),
    .senderIdx   (senderIdx),
    .tgtPresent  (tgtPresent),
    .tgtPhysId   (tgtPhysId),
    .tgtLogReg   (tgtLogReg),
    .tgtFmtReg   (tgtFmtReg),
    .deliverMask (deliverMask)
  );

endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk #(
  parameter int unsigned N = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [31:0]      reqCmd,
  input logic [IDX_W-1:0] senderIdx,
  input logic [N-1:0]     tgtPresent,
  input logic             maskValid,
  input logic [N-1:0]     deliverMask
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> maskValid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !maskValid); // R2

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(deliverMask)); // R11

  AST_ONLY_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ((deliverMask & ~$past(tgtPresent)) == '0)); // R10

  AST_LOWEST_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCmd[10:8] == 3'd1) |=> $onehot0(deliverMask)); // R9

  AST_SELF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCmd[19:18] == 2'd1) |=> ($countones(deliverMask) <= 1)); // R8

  AST_SELF_EXCLUDED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCmd[19:18] == 2'd3 && 32'(senderIdx) < N)
      |=> !deliverMask[$past(senderIdx)]); // R8

endmodule

bind irq_target_sel irq_sel_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqCmd      (reqCmd),
  .senderIdx   (senderIdx),
  .tgtPresent  (tgtPresent),
  .maskValid   (maskValid),
  .deliverMask (deliverMask)
);

// File: tb/sim_irq_target_sel.sv
`timescale 1ns/1ps
module sim_irq_target_sel;

  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [31:0]   reqCmd = '0;
  logic [7:0]    destId = '0;
  logic [2:0]    senderIdx = '0;
  logic [N-1:0]  tgtPresent = '0;
  logic [N*8-1:0]  tgtPhysId = '0;
  logic [N*32-1:0] tgtLogReg = '0;
  logic [N*32-1:0] tgtFmtReg = '0;
  logic          maskValid;
  logic [N-1:0]  deliverMask;

  int checks = 0;
  int errors = 0;

  logic [7:0] cfgPhys  [N];
  logic [7:0] cfgLog   [N];
  logic [3:0] cfgModel [N];
  logic [N-1:0] cfgPres;

  always #10 clk = ~clk;

  irq_target_sel #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .destId(destId), .senderIdx(senderIdx), .tgtPresent(tgtPresent),
    .tgtPhysId(tgtPhysId), .tgtLogReg(tgtLogReg), .tgtFmtReg(tgtFmtReg),
    .maskValid(maskValid), .deliverMask(deliverMask)
  );

  task automatic applyCfg();
    for (int i = 0; i < N; i++) begin
      tgtPhysId[i*8 +: 8]  = cfgPhys[i];
      tgtLogReg[i*32 +: 32] = {cfgLog[i], 24'h5A_C3_96};
      tgtFmtReg[i*32 +: 32] = {cfgModel[i], 28'hFFF_FFFF};
    end
    tgtPresent = cfgPres;
  endtask

  function automatic logic [N-1:0] model(int sh, int dm, int dest, int snd, int mode);
    logic [N-1:0] m;
    logic [7:0] d;
    d = 8'(dest);
    m = '0;
    for (int i = 0; i < N; i++) begin
      logic hit;
      hit = 1'b0;
      case (sh)
        0: begin
          if (dm == 0) hit = (d == 8'hFF) || (cfgPhys[i] == d);
          else if (cfgModel[i] == 4'hF) hit = (d & cfgLog[i]) != 0;
          else if (cfgModel[i] == 4'h0)
            hit = (d[7:4] == cfgLog[i][7:4]) && ((d[3:0] & cfgLog[i][3:0]) != 0);
        end
        1: hit = (i == snd);
        2: hit = 1'b1;
        default: hit = (i != snd);
      endcase
      m[i] = hit && cfgPres[i];
    end
    if (mode == 1) begin
      logic [N-1:0] low;
      low = '0;
      for (int i = N - 1; i >= 0; i--) if (m[i]) low = N'(1) << i;
      m = low;
    end
    return m;
  endfunction

  function automatic string tagOf(int sh, int dm, int dest, int mode);
    if (mode == 1) return "R9";
    if (sh != 0) return "R8";
    if (dm == 0) return (dest == 255) ? "R3" : "R4";
    return "R5_R6_R7";
  endfunction

  task automatic check(string tag, logic v, logic [N-1:0] m, logic ev, logic [N-1:0] em);
    checks++;
    if (v !== ev || m !== em) begin
      errors++;
      $display("FAIL %s: valid=%0b mask=%02h expected valid=%0b mask=%02h",
               tag, v, m, ev, em);
    end
  endtask

  task automatic issue(int sh, int dm, int dest, int snd, int mode, string tag);
    @(negedge clk);
    reqValid  = 1'b1;
    reqCmd    = (32'(sh) << 18) | (32'(dm) << 11) | (32'(mode) << 8) | 32'h0000_0041;
    destId    = 8'(dest);
    senderIdx = 3'(snd);
    @(posedge clk);
    #2;
    check(tag, maskValid, deliverMask, 1'b1, model(sh, dm, dest, snd, mode));
  endtask

  task automatic loadCfg(int c);
    for (int i = 0; i < N; i++) begin
      case (c)
        0: begin cfgPhys[i] = 8'(i); cfgLog[i] = 8'(1 << i); cfgModel[i] = 4'hF; end
        1: begin
          cfgPhys[i] = 8'(8'h10 + i);
          cfgLog[i] = {4'(i / 4 + 1), 4'(1 << (i % 4))};
          cfgModel[i] = 4'h0;
        end
        default: begin
          cfgPhys[i] = 8'(8'hF7 - i);
          cfgLog[i] = (i % 2 == 0) ? 8'(1 << i) : 8'hFF;
          cfgModel[i] = (i % 2 == 0) ? 4'hF : 4'h5;
        end
      endcase
    end
    cfgPres = (c == 1) ? 8'hEF : 8'hFF;
  endtask

  initial begin
    loadCfg(0);
    applyCfg();
    repeat (3) @(posedge clk);
    #2;
    check("R1", maskValid, deliverMask, 1'b0, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check("R1", maskValid, deliverMask, 1'b0, '0);

    for (int c = 0; c < 3; c++) begin
      loadCfg(c);
      @(negedge clk);
      applyCfg();
      for (int sh = 0; sh < 4; sh++)
        for (int dm = 0; dm < 2; dm++)
          for (int mode = 0; mode < 2; mode++)
            for (int dest = 0; dest < 256; dest++)
              issue(sh, dm, dest, dest % N, mode, tagOf(sh, dm, dest, mode));
    end

    // R7: invalid models (odd targets in config 2) never match in logical mode
    loadCfg(2);
    @(negedge clk);
    applyCfg();
    issue(0, 1, 255, 0, 0, "R7");
    check("R7", maskValid, deliverMask, 1'b1, 8'h55);

    // R4: no physical match gives empty mask
    issue(0, 0, 8'h33, 0, 0, "R4");
    check("R4", maskValid, deliverMask, 1'b1, 8'h00);

    // R10: absent target 4 excluded from broadcast and all-including shorthand
    loadCfg(1);
    @(negedge clk);
    applyCfg();
    issue(0, 0, 255, 0, 0, "R10");
    check("R10", maskValid, deliverMask, 1'b1, 8'hEF);
    issue(2, 0, 0, 0, 0, "R10");
    check("R10", maskValid, deliverMask, 1'b1, 8'hEF);

    // R6: cluster 2 lower bits 0011 selects targets 4(absent) and 5 -> only 5
    issue(0, 1, 8'h23, 0, 0, "R6");
    check("R6", maskValid, deliverMask, 1'b1, 8'h20);

    // R2 and R11: no strobe -> valid drops, mask holds despite input changes
    @(negedge clk);
    reqValid = 1'b0;
    destId   = 8'hFF;
    reqCmd   = 32'h0008_0000;
    @(posedge clk);
    #2;
    check("R2_R11", maskValid, deliverMask, 1'b0, 8'h20);
    @(posedge clk);
    #2;
    check("R11", maskValid, deliverMask, 1'b0, 8'h20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule